// File: doc/BRIEF.md
# Per-Stream Input Frame Offset Calibrator

This block finds out how far each serial input stream's frame boundary lags the reference frame pulse, and then retimes every stream by its own delay so that all streams can be sampled in step. Software picks one stream and sets a start bit in a control register. The block then waits for the next reference frame pulse and counts master-clock ticks until the frame marker of the chosen stream appears. It stores that count, with a valid flag, in a result register and clears the start bit by itself. If no marker arrives within one frame length of ticks, a timeout flag is set instead.

Each stream also has its own delay register, written by software. This register sets how many extra ticks that stream's data passes through a tapped shift line before it reaches the output. Software can read the measured offsets and turn them into delay settings. All registers are reached through one flat word-wide register port. The asynchronous active-low reset is released in step with the clock.

Top module: `frame_ofs_cal`

## Requirements
- R1: After reset, the control, result and all delay registers read 0, and every `st_out` bit is 0.
- R2: A write to address 0 loads the start bit from data bit 0 and the stream index from data bits [SEL_W:1]. The register reads back the same way. Writing the start bit as 1 clears the result's value, valid flag and timeout flag.
- R3: While start is 1, the first cycle in which `ref_frm` is high is tick 0. If the selected stream's `st_mark` is high k ticks later (k = 0 when it is high in the same cycle), the result at address 1 reads k in its low bits, with the valid flag in bit 15 set and the timeout flag in bit 14 clear.
- R4: In the cycle after a measurement ends, with a valid result or with a timeout, the start bit reads 0.
- R5: If the selected marker is not seen on ticks 0 to FRAME_TICKS-1, the timeout bit (14) is set, the valid bit and the value are 0, and start clears. A marker on tick FRAME_TICKS-1 still gives a valid result.
- R6: Markers on streams that are not selected have no effect on a measurement. Reference pulses and markers have no effect while the start bit is 0.
- R7: If a control write lands in the same cycle as a measurement's completion, the write wins. The completing result is discarded, the written start and index take hold, and a written start of 1 arms a new measurement.
- R8: Stream k's delay register sits at address 2+k and is OFS_W bits wide. It reads back what was written. Unmapped addresses read 0.
- R9: `st_out[k]` equals `st_in[k]` as it was sampled D+1 clock edges earlier, where D is stream k's delay register.
- R10: The result register is read-only. Writes to address 1 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_frm | input | 1 | Reference frame pulse, active high for one tick |
| st_mark | input | N_STR | Per-stream frame marker, active high |
| st_in | input | N_STR | Serial stream data in |
| st_out | output | N_STR | Retimed serial stream data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |

## Verification
Two functions can fall in the same cycle. In one, software writes the control register while the hardware is completing a measurement and clearing the start bit. The bench drives a control write on exactly the tick at which the selected marker arrives. It then expects the written start and index to read back with an empty result, followed by a fresh, correct measurement on the next reference pulse. In the other case, a marker coincides with the reference pulse itself, which must yield an offset of 0. A stream's delay tap also changes while the data history is still in flight. The bench does not compare outputs until the new delay has filled with the new pattern.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned VLD_BIT  = 15;
  localparam int unsigned TMO_BIT  = 14;
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_RES  = 1;
  localparam int unsigned ADR_OFS0 = 2;

  typedef enum logic {
    M_IDLE = 1'b0,
    M_RUN  = 1'b1
  } meter_st_e;
endpackage

// File: rtl/ofc_meter.sv
module ofc_meter
  import ofc_pkg::*;
#(
  parameter int unsigned N_STR       = 24,
  parameter int unsigned FRAME_TICKS = 2048,
  parameter int unsigned SEL_W       = 5,
  parameter int unsigned CNT_W       = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic             ref_frm,
  input  logic [N_STR-1:0] mark,
  output logic             done,
  output logic             tmo,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

  meter_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             mark_sel;

  always_comb begin
    mark_sel = 1'b0;
    for (int i = 0; i < N_STR; i++) begin
      if (sel == SEL_W'(i)) mark_sel = mark[i];
    end
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    tmo    = 1'b0;
    value  = cnt_q;
    if (restart) begin
      st_d  = M_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        M_IDLE: begin
          if (start && ref_frm) begin
            if (mark_sel) begin
              done  = 1'b1;
              value = '0;
            end else begin
              st_d  = M_RUN;
              cnt_d = CNT_W'(1);
            end
          end
        end
        M_RUN: begin
          if (!start) begin
            st_d  = M_IDLE;
            cnt_d = '0;
          end else if (mark_sel) begin
            done  = 1'b1;
            st_d  = M_IDLE;
            cnt_d = '0;
          end else if (cnt_q == LAST) begin
            tmo   = 1'b1;
            st_d  = M_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          st_d  = M_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign cnt_en = (st_d != st_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      cnt_q <= '0;
    end else if (cnt_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ofc_regs.sv
module ofc_regs
  import ofc_pkg::*;
#(
  parameter int unsigned N_STR  = 24,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned OFS_W  = 6,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  input  logic                   done,
  input  logic                   tmo,
  input  logic [CNT_W-1:0]       value,
  output logic                   start,
  output logic [SEL_W-1:0]       sel,
  output logic                   ctrl_wr,
  output logic                   res_vld,
  output logic                   res_tmo,
  output logic [N_STR*OFS_W-1:0] ofs_flat
);
  logic             start_q, start_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             vld_q, vld_d, tmo_q, tmo_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic             ctrl_en, res_en;
  logic [OFS_W-1:0] ofs_q [N_STR];

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));

  always_comb begin
    start_d = start_q;
    sel_d   = sel_q;
    if (ctrl_wr) begin
      start_d = reg_wdata[0];
      sel_d   = reg_wdata[SEL_W:1];
    end else if (done || tmo) begin
      start_d = 1'b0;
    end
  end

  always_comb begin
    vld_d = vld_q;
    tmo_d = tmo_q;
    val_d = val_q;
    if (ctrl_wr) begin
      if (reg_wdata[0]) begin
        vld_d = 1'b0;
        tmo_d = 1'b0;
        val_d = '0;
      end
    end else if (done) begin
      vld_d = 1'b1;
      tmo_d = 1'b0;
      val_d = value;
    end else if (tmo) begin
      vld_d = 1'b0;
      tmo_d = 1'b1;
      val_d = '0;
    end
  end

  assign ctrl_en = ctrl_wr || done || tmo;
  assign res_en  = (ctrl_wr && reg_wdata[0]) || done || tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      sel_q   <= '0;
    end else if (ctrl_en) begin
      start_q <= start_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tmo_q <= 1'b0;
      val_q <= '0;
    end else if (res_en) begin
      vld_q <= vld_d;
      tmo_q <= tmo_d;
      val_q <= val_d;
    end
  end

  for (genvar k = 0; k < N_STR; k++) begin : g_ofs
    logic ofs_en;
    assign ofs_en = reg_wr && (reg_addr == ADDR_W'(ADR_OFS0 + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ofs_q[k] <= '0;
      else if (ofs_en) ofs_q[k] <= reg_wdata[OFS_W-1:0];
    end
    assign ofs_flat[k*OFS_W +: OFS_W] = ofs_q[k];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADR_CTRL)) begin
      reg_rdata[0]       = start_q;
      reg_rdata[SEL_W:1] = sel_q;
    end else if (reg_addr == ADDR_W'(ADR_RES)) begin
      reg_rdata[CNT_W-1:0] = val_q;
      reg_rdata[VLD_BIT]   = vld_q;
      reg_rdata[TMO_BIT]   = tmo_q;
    end
    for (int i = 0; i < N_STR; i++) begin
      if (reg_addr == ADDR_W'(ADR_OFS0 + i)) reg_rdata[OFS_W-1:0] = ofs_q[i];
    end
  end

  assign start   = start_q;
  assign sel     = sel_q;
  assign res_vld = vld_q;
  assign res_tmo = tmo_q;
endmodule

// File: rtl/ofc_delay.sv
module ofc_delay #(
  parameter int unsigned OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [OFS_W-1:0] ofs,
  output logic             dout
);
  localparam int unsigned DEPTH = 2 ** OFS_W;

  logic [DEPTH-1:0] line_q, line_d;

  always_comb begin
    line_d = {line_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign dout = line_q[ofs];
endmodule

// File: rtl/frame_ofs_cal.sv
module frame_ofs_cal
  import ofc_pkg::*;
#(
  parameter int unsigned N_STR       = 24,
  parameter int unsigned FRAME_TICKS = 2048,
  parameter int unsigned OFS_W       = 6,
  parameter int unsigned ADDR_W      = $clog2(N_STR + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_frm,
  input  logic [N_STR-1:0]  st_mark,
  input  logic [N_STR-1:0]  st_in,
  output logic [N_STR-1:0]  st_out,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata
);
  localparam int unsigned SEL_W = (N_STR > 1) ? $clog2(N_STR) : 1;
  localparam int unsigned CNT_W = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;

  logic                   rst_m_n, rst_s_n;
  logic                   start_w, ctrl_wr_w, done_w, tmo_w;
  logic                   res_vld_w, res_tmo_w;
  logic [SEL_W-1:0]       sel_w;
  logic [CNT_W-1:0]       value_w;
  logic [N_STR*OFS_W-1:0] ofs_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  ofc_regs #(
    .N_STR(N_STR), .SEL_W(SEL_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_s_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done(done_w), .tmo(tmo_w), .value(value_w),
    .start(start_w), .sel(sel_w), .ctrl_wr(ctrl_wr_w),
    .res_vld(res_vld_w), .res_tmo(res_tmo_w), .ofs_flat(ofs_w)
  );

  ofc_meter #(
    .N_STR(N_STR), .FRAME_TICKS(FRAME_TICKS), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) meter_i (
    .clk(clk), .rst_n(rst_s_n),
    .start(start_w), .sel(sel_w), .restart(ctrl_wr_w),
    .ref_frm(ref_frm), .mark(st_mark),
    .done(done_w), .tmo(tmo_w), .value(value_w)
  );

  for (genvar k = 0; k < N_STR; k++) begin : g_dly
    ofc_delay #(.OFS_W(OFS_W)) dly_i (
      .clk(clk), .rst_n(rst_s_n),
      .din(st_in[k]), .ofs(ofs_w[k*OFS_W +: OFS_W]), .dout(st_out[k])
    );
  end
endmodule

// File: rtl/ofc_chk.sv
module ofc_chk #(
  parameter int unsigned N_STR = 24,
  parameter int unsigned OFS_W = 6
) (
  input logic                   clk,
  input logic                   rst_s_n,
  input logic                   start_w,
  input logic                   ctrl_wr_w,
  input logic                   done_w,
  input logic                   tmo_w,
  input logic                   res_vld_w,
  input logic                   res_tmo_w,
  input logic [15:0]            reg_wdata,
  input logic [N_STR*OFS_W-1:0] ofs_w,
  input logic [N_STR-1:0]       st_in,
  input logic [N_STR-1:0]       st_out
);
  logic [OFS_W-1:0] ofs0;
  assign ofs0 = ofs_w[OFS_W-1:0];

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((done_w || tmo_w) && !ctrl_wr_w) |=> !start_w);

  // R5
  vld_tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(res_vld_w && res_tmo_w));

  // R3
  vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(res_vld_w) |-> $past(done_w));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!done_w && !tmo_w && !ctrl_wr_w) |=> ($stable(res_vld_w) && $stable(res_tmo_w)));

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctrl_wr_w && reg_wdata[0]) |=> (start_w && !res_vld_w && !res_tmo_w));

  // R9
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ofs0 == '0) |=> (!$stable(ofs0) || (st_out[0] == $past(st_in[0]))));
endmodule

bind frame_ofs_cal ofc_chk #(.N_STR(N_STR), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst_s_n(rst_s_n), .start_w(start_w), .ctrl_wr_w(ctrl_wr_w),
  .done_w(done_w), .tmo_w(tmo_w), .res_vld_w(res_vld_w), .res_tmo_w(res_tmo_w),
  .reg_wdata(reg_wdata), .ofs_w(ofs_w), .st_in(st_in), .st_out(st_out)
);

// File: tb/frame_ofs_cal_tb_top.sv
module frame_ofs_cal_tb_top;
  localparam int N  = 4;
  localparam int FT = 32;
  localparam int OW = 3;
  localparam int AW = 3;

  logic          clk;
  logic          rst_n;
  logic          ref_frm;
  logic [N-1:0]  st_mark, st_in, st_out;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [15:0]   reg_wdata, reg_rdata;

  int n_run, n_fail;
  bit finished;

  frame_ofs_cal #(.N_STR(N), .FRAME_TICKS(FT), .OFS_W(OW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_frm(ref_frm), .st_mark(st_mark),
    .st_in(st_in), .st_out(st_out), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = AW'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  // One measurement on stream s; marker at tick k (k < 0: never). Others mark at another tick.
  task automatic meas(input int s, input int k, input bit arm);
    if (arm) wr(0, (s << 1) | 1);
    for (int c = 0; c < FT + 2; c++) begin
      @(negedge clk);
      ref_frm = (c == 0);
      for (int o = 0; o < N; o++) begin
        if (o == s) st_mark[o] = (c == k);
        else        st_mark[o] = (k >= 0) ? (c == (k + 1) % FT) : (c == 3);
      end
    end
    @(negedge clk);
    ref_frm = 1'b0; st_mark = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int v, v2;
    logic [N-1:0] hist [0:31];
    logic [7:0] lfsr;
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; ref_frm = 1'b0; st_mark = '0; st_in = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < N + 2; a++) begin
      rd(a, v); check("R1 reg reset", v, 0);
    end
    check("R1 st_out reset", int'(st_out), 0);

    // R8 offset readback and unmapped reads
    for (int s = 0; s < N; s++) begin
      wr(2 + s, 16'hFFF8 | (s + 3));
      rd(2 + s, v); check("R8 ofs readback", v, (s + 3) % 8);
    end
    rd(6, v); check("R8 unmapped", v, 0);
    rd(7, v); check("R8 unmapped", v, 0);

    // R2 control readback
    wr(0, 16'h0006);
    rd(0, v); check("R2 ctrl readback", v, 6);

    // R3 / R4 / R6 sweep of streams and ticks
    for (int s = 0; s < N; s++) begin
      foreach (hist[i]) hist[i] = '0;
      for (int t = 0; t < 5; t++) begin
        int k;
        k = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? (5 + s) : (t == 3) ? FT - 2 : FT - 1;
        meas(s, k, 1'b1);
        rd(1, v); check("R3 result", v, 16'h8000 | k);
        rd(0, v); check("R4 start cleared", v, s << 1);
      end
    end

    // R5 timeout with other streams marking
    meas(2, -1, 1'b1);
    rd(1, v); check("R5 timeout", v, 16'h4000);
    rd(0, v); check("R5 start cleared", v, 2 << 1);

    // R2 new start clears timeout
    wr(0, (1 << 1) | 1);
    rd(1, v); check("R2 start clears result", v, 0);
    meas(1, 9, 1'b0);
    rd(1, v); check("R3 after restart", v, 16'h8009);

    // R6 idle: pulses with start=0 ignored
    meas(1, 4, 1'b0);
    rd(1, v); check("R6 idle ignored", v, 16'h8009);

    // R10 result read-only
    wr(1, 16'hFFFF);
    rd(1, v); check("R10 result ro", v, 16'h8009);

    // R7 write lands on completion tick
    wr(0, (3 << 1) | 1);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ref_frm = (c == 0);
      st_mark[3] = (c == 4);
      reg_wr = (c == 4); reg_addr = '0; reg_wdata = 16'((3 << 1) | 1);
    end
    @(negedge clk);
    ref_frm = 1'b0; st_mark = '0; reg_wr = 1'b0;
    rd(0, v); check("R7 write wins ctrl", v, 7);
    rd(1, v); check("R7 result discarded", v, 0);
    meas(3, 6, 1'b0);
    rd(1, v); check("R7 rearmed measure", v, 16'h8006);

    // R9 delay sweep
    lfsr = 8'hA5;
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < 8; d++) begin
        wr(2 + s, d);
        for (int m = 0; m < 20; m++) begin
          @(negedge clk);
          if (m - 1 - d >= 0) check("R9 delay", int'(st_out[s]), int'(hist[m - 1 - d][s]));
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          st_in = lfsr[N-1:0];
          hist[m] = lfsr[N-1:0];
        end
      end
    end
    rd(2, v2); check("R8 final ofs", v2, 7);

    summary();
  end
endmodule